// File: doc/BRIEF.md
# Triggered Ping-Pong Capture Buffer

An analog-to-digital converter delivers samples without pause, but only the stretch right after a trigger is of use. On each rising edge of an asynchronous trigger, this block records a block of samples of fixed length into one of two memory banks. Every block starts at word zero of its bank, so a reader always knows where each sample of a capture sits. The next capture goes into the other bank, and a host drains the bank that was just filled. The window is typically about 200 us of samples, and triggers come every 1 to 2 ms.

Each bank has a dirty flag. The flag is set when a capture into that bank finishes and cleared when the host pulses that bank's release strobe. The host may still be holding the bank the next trigger would fill. A policy input then decides between two actions. In hold-off mode the trigger is dropped and the bank is left intact. In overwrite mode the bank is refilled. Both actions raise a sticky overflow flag. A trigger that comes while a capture is still running is dropped and counted in a saturating counter. A synchronous read port with one cycle of latency gives the host access to either bank.

Top module: `trig_pingpong_capture`

## Requirements
- R1: The trigger passes through a two-stage synchronizer. A capture is accepted on the clock edge two cycles after the first edge that samples the trigger high. Exactly one acceptance happens per rising edge, however long the trigger stays high.
- R2: An accepted capture stores the next CAP_LEN valid samples, beginning with the first valid sample after the accepting edge, at addresses 0 to CAP_LEN-1 of the target bank, in order.
- R3: Captures alternate banks, starting with bank 0 after reset. `last_bank` reports the bank of the most recently completed capture and is 0 after reset.
- R4: `bank_ready[b]` (bit 0 for bank 0, bit 1 for bank 1) rises on the edge that stores a bank's final sample. It clears on a clock edge where `host_release[b]` is high. A completion on the same edge takes priority over a release.
- R5: With `policy_overwrite` = 0, a trigger whose target bank is dirty starts no capture. The bank contents, `last_bank` and the target bank stay unchanged.
- R6: With `policy_overwrite` = 1, a trigger whose target bank is dirty refills that bank. The bank's ready bit is still set when the capture completes.
- R7: `overflow` is set by any trigger accepted while its target bank is dirty. It holds until a cycle with `host_ovf_clr` high. A set on the same edge as a clear takes priority.
- R8: A trigger edge detected while a capture is running is ignored. It increments `missed_count`, which saturates at 2^MISS_W-1.
- R9: `host_rd_data` returns the word at {`host_rd_bank`, `host_rd_addr`} one cycle after those inputs are sampled. A write to the same word on that edge is not reflected.
- R10: A cycle with `adc_valid` low stores nothing and does not advance the capture position. Samples outside a capture are discarded.
- R11: Synchronous reset clears the ready bits, overflow, the missed count and `last_bank`, and aborts any capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_data | input | SAMPLE_W | Sample from the converter stream |
| adc_valid | input | 1 | Sample on adc_data is valid this cycle |
| trig_in | input | 1 | Asynchronous capture trigger, rising edge |
| policy_overwrite | input | 1 | 0: drop a trigger aimed at a dirty bank; 1: overwrite it |
| host_release | input | 2 | Per-bank strobe: the host has finished reading that bank |
| host_ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| host_rd_bank | input | 1 | Bank selected for reading |
| host_rd_addr | input | ADDR_W | Word address within the bank |
| host_rd_data | output | SAMPLE_W | Read data, one cycle after address |
| bank_ready | output | 2 | Per-bank dirty flag: a complete, unreleased capture |
| last_bank | output | 1 | Bank of the most recently completed capture |
| overflow | output | 1 | Sticky: a trigger found its target bank dirty |
| missed_count | output | MISS_W | Saturating count of triggers dropped mid-capture |

## Verification
A counter that slips a word or a bank pointer that misses a toggle appears on `host_rd_data` at the first read of the affected word, one cycle after the address. The bench sweeps both banks all the time, so such a fault shows up within one sweep of the bank length. A wrong dirty or policy decision shows up on `bank_ready`, `overflow` or `last_bank` on the edge after the trigger is accepted, or when the capture completes. A synchronizer or edge-detector fault shifts every stored sample by one position, or starts extra captures, and this shows up in the read data and in `missed_count`.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_FILL = 1'b1
  } cap_state_t;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/cap_trig_sync.sv
module cap_trig_sync (
  input  logic clk,
  input  logic rst,
  input  logic trig_async,
  output logic trig_pulse
);
  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= trig_async;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign trig_pulse = sync_q & ~hist_q;

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |=> !trig_pulse);
endmodule

// File: rtl/cap_bank_ram.sv
module cap_bank_ram #(
  parameter int DATA_W = 12,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= store[raddr];
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int CAP_LEN = 256,
  parameter int ADDR_W  = 8,
  parameter int MISS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_pulse,
  input  logic              adc_valid,
  input  logic              policy_overwrite,
  input  logic [1:0]        host_release,
  input  logic              host_ovf_clr,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        bank_ready,
  output logic              last_bank,
  output logic              overflow,
  output logic [MISS_W-1:0] missed_count
);
  localparam logic [ADDR_W-1:0] LAST_POS = ADDR_W'(CAP_LEN - 1);
  localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

  cap_state_t        state;
  logic [ADDR_W-1:0] pos;
  logic              fill_bank;
  logic              next_bank;
  logic [1:0]        dirty;
  logic              ovf_q;
  logic [MISS_W-1:0] miss_q;
  logic              last_q;

  logic accept, target_dirty, start, ovf_set, miss, at_end;

  always_comb begin
    accept       = trig_pulse && (state == CAP_IDLE);
    target_dirty = dirty[next_bank];
    start        = accept && (!target_dirty || policy_overwrite);
    ovf_set      = accept && target_dirty;
    miss         = trig_pulse && (state == CAP_FILL);
    at_end       = (state == CAP_FILL) && adc_valid && (pos == LAST_POS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CAP_IDLE;
      pos       <= '0;
      fill_bank <= 1'b0;
      next_bank <= 1'b0;
      last_q    <= 1'b0;
    end else if (start) begin
      state     <= CAP_FILL;
      pos       <= '0;
      fill_bank <= next_bank;
    end else if (state == CAP_FILL && adc_valid) begin
      if (at_end) begin
        state     <= CAP_IDLE;
        last_q    <= fill_bank;
        next_bank <= ~fill_bank;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dirty
    always_ff @(posedge clk) begin
      if (rst) dirty[b] <= 1'b0;
      else     dirty[b] <= (dirty[b] & ~host_release[b]) |
                           (at_end && (fill_bank == 1'(b)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q  <= 1'b0;
      miss_q <= '0;
    end else begin
      ovf_q <= (ovf_q & ~host_ovf_clr) | ovf_set;
      if (miss && miss_q != MISS_MAX) miss_q <= miss_q + 1'b1;
    end
  end

  assign wr_en        = (state == CAP_FILL) && adc_valid;
  assign wr_bank      = fill_bank;
  assign wr_addr      = pos;
  assign bank_ready   = dirty;
  assign last_bank    = last_q;
  assign overflow     = ovf_q;
  assign missed_count = miss_q;

  assert_end_to_idle_R2: assert property (@(posedge clk) disable iff (rst)
    at_end |=> (state == CAP_IDLE));
  assert_ready_after_fill_R4: assert property (@(posedge clk) disable iff (rst)
    at_end |=> (bank_ready[last_bank] && last_bank == $past(fill_bank)));
  assert_halt_skips_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf_set && !policy_overwrite) |=> (state == CAP_IDLE));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (overflow && !host_ovf_clr) |=> overflow);
  assert_miss_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (missed_count == MISS_MAX) |=> (missed_count == MISS_MAX));
  assert_no_write_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (state == CAP_IDLE && !start) |=> !(wr_en && pos != '0));
endmodule

// File: rtl/trig_pingpong_capture.sv
module trig_pingpong_capture #(
  parameter int SAMPLE_W = 12,
  parameter int CAP_LEN  = 256,
  parameter int MISS_W   = 4,
  localparam int ADDR_W  = (CAP_LEN > 1) ? $clog2(CAP_LEN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic                adc_valid,
  input  logic                trig_in,
  input  logic                policy_overwrite,
  input  logic [1:0]          host_release,
  input  logic                host_ovf_clr,
  input  logic                host_rd_bank,
  input  logic [ADDR_W-1:0]   host_rd_addr,
  output logic [SAMPLE_W-1:0] host_rd_data,
  output logic [1:0]          bank_ready,
  output logic                last_bank,
  output logic                overflow,
  output logic [MISS_W-1:0]   missed_count
);
  localparam int RAM_AW = ADDR_W + 1;

  logic              trig_pulse;
  logic              wr_en, wr_bank;
  logic [ADDR_W-1:0] wr_addr;

  cap_trig_sync u_sync (
    .clk        (clk),
    .rst        (rst),
    .trig_async (trig_in),
    .trig_pulse (trig_pulse)
  );

  cap_ctrl #(
    .CAP_LEN (CAP_LEN),
    .ADDR_W  (ADDR_W),
    .MISS_W  (MISS_W)
  ) u_ctrl (
    .clk              (clk),
    .rst              (rst),
    .trig_pulse       (trig_pulse),
    .adc_valid        (adc_valid),
    .policy_overwrite (policy_overwrite),
    .host_release     (host_release),
    .host_ovf_clr     (host_ovf_clr),
    .wr_en            (wr_en),
    .wr_bank          (wr_bank),
    .wr_addr          (wr_addr),
    .bank_ready       (bank_ready),
    .last_bank        (last_bank),
    .overflow         (overflow),
    .missed_count     (missed_count)
  );

  cap_bank_ram #(
    .DATA_W (SAMPLE_W),
    .AW     (RAM_AW)
  ) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr ({wr_bank, wr_addr}),
    .wdata (adc_data),
    .raddr ({host_rd_bank, host_rd_addr}),
    .rdata (host_rd_data)
  );
endmodule

// File: tb/trig_pingpong_capture_test.sv
`timescale 1ns/100ps
module trig_pingpong_capture_test;
  localparam int SW   = 12;
  localparam int LEN  = 16;
  localparam int MW   = 4;
  localparam int AW   = 4;
  localparam int MMAX = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] adc_data = '0;
  logic          adc_valid = 1'b1;
  logic          trig_in = 1'b0;
  logic          policy_overwrite = 1'b0;
  logic [1:0]    host_release = '0;
  logic          host_ovf_clr = 1'b0;
  logic          host_rd_bank = 1'b0;
  logic [AW-1:0] host_rd_addr = '0;
  logic [SW-1:0] host_rd_data;
  logic [1:0]    bank_ready;
  logic          last_bank, overflow;
  logic [MW-1:0] missed_count;

  trig_pingpong_capture #(.SAMPLE_W(SW), .CAP_LEN(LEN), .MISS_W(MW)) uut (
    .clk(clk), .rst(rst), .adc_data(adc_data), .adc_valid(adc_valid),
    .trig_in(trig_in), .policy_overwrite(policy_overwrite),
    .host_release(host_release), .host_ovf_clr(host_ovf_clr),
    .host_rd_bank(host_rd_bank), .host_rd_addr(host_rd_addr),
    .host_rd_data(host_rd_data), .bank_ready(bank_ready),
    .last_bank(last_bank), .overflow(overflow), .missed_count(missed_count)
  );

  always #2.5 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string phase    = "R11_reset";
  bit    gap_mode = 1'b0;
  bit    done     = 1'b0;

  // reference model state
  int m_trig [3];
  bit m_busy;
  int m_pos, m_fill, m_next, m_last, m_ovf, m_miss;
  int m_dirty [2];
  int m_mem [int];
  int e_rd;
  bit e_rd_known;

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h", req, phase, what, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m_trig[i]) m_trig[i] = 0;
    m_busy = 0; m_pos = 0; m_fill = 0; m_next = 0; m_last = 0;
    m_ovf = 0; m_miss = 0; m_dirty[0] = 0; m_dirty[1] = 0;
    e_rd_known = 0;
  endtask

  always @(posedge clk) begin
    int  s_data, s_valid, s_trig, s_pol, s_rel, s_clr, s_rb, s_ra;
    bit  pulse, busy0, ovf_set, done_now;
    int  d0 [2];
    int  key;
    s_data = int'(adc_data); s_valid = int'(adc_valid); s_trig = int'(trig_in);
    s_pol = int'(policy_overwrite); s_rel = int'(host_release);
    s_clr = int'(host_ovf_clr); s_rb = int'(host_rd_bank); s_ra = int'(host_rd_addr);
    if (rst) begin
      model_reset();
    end else begin
      key = s_rb * LEN + s_ra;
      e_rd_known = m_mem.exists(key);
      if (e_rd_known) e_rd = m_mem[key];
      pulse = (m_trig[1] != 0) && (m_trig[2] == 0);
      m_trig[2] = m_trig[1]; m_trig[1] = m_trig[0]; m_trig[0] = s_trig;
      busy0 = m_busy; d0 = m_dirty; ovf_set = 0; done_now = 0;
      if (busy0 && s_valid != 0) begin
        m_mem[m_fill * LEN + m_pos] = s_data;
        if (m_pos == LEN - 1) begin
          m_busy = 0; done_now = 1; m_last = m_fill; m_next = 1 - m_fill;
        end else m_pos++;
      end
      if (pulse && busy0) begin
        if (m_miss < MMAX) m_miss++;
      end else if (pulse) begin
        if (d0[m_next] != 0) ovf_set = 1;
        if (d0[m_next] == 0 || s_pol != 0) begin
          m_busy = 1; m_pos = 0; m_fill = m_next;
        end
      end
      for (int b = 0; b < 2; b++)
        m_dirty[b] = ((d0[b] != 0 && ((s_rel >> b) & 1) == 0) ||
                      (done_now && m_last == b)) ? 1 : 0;
      m_ovf = ((m_ovf != 0 && s_clr == 0) || ovf_set) ? 1 : 0;
    end
    #1;
    check("R4", "bank_ready", int'(bank_ready), m_dirty[1] * 2 + m_dirty[0]);
    check("R3", "last_bank", int'(last_bank), m_last);
    check("R7", "overflow", int'(overflow), m_ovf);
    check("R8", "missed_count", int'(missed_count), m_miss);
    if (!rst && e_rd_known) check("R2 R9", "host_rd_data", int'(host_rd_data), e_rd);
  end

  // free-running sample stream and continuous read sweep across both banks
  always @(negedge clk) begin
    adc_data <= adc_data + 12'd7;
    if (gap_mode) adc_valid <= ~adc_valid;
    {host_rd_bank, host_rd_addr} <= {host_rd_bank, host_rd_addr} + 1'b1;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire(int hi, int lo);
    @(negedge clk); trig_in = 1'b1;
    idle(hi);
    trig_in = 1'b0;
    idle(lo);
  endtask

  task automatic release_bank(int b);
    @(negedge clk); host_release = 2'(1 << b);
    @(negedge clk); host_release = '0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    model_reset();
    idle(4);
    phase = "R11_reset";
    check("R11", "reset bank_ready", int'(bank_ready), 0);
    check("R11", "reset overflow", int'(overflow), 0);
    check("R11", "reset missed", int'(missed_count), 0);
    rst = 1'b0;

    phase = "R1_long_trigger";
    fire(LEN + 20, 10);
    check("R1", "one capture into bank 0", int'(bank_ready), 1);

    phase = "R3_alternate";
    fire(3, LEN + 10);
    check("R3", "second capture in bank 1", int'(last_bank), 1);

    phase = "R5_halt";
    policy_overwrite = 1'b0;
    fire(3, LEN + 10);
    check("R5", "skip keeps last_bank", int'(last_bank), 1);
    check("R5", "overflow raised", int'(overflow), 1);

    phase = "R7_clear";
    @(negedge clk); host_ovf_clr = 1'b1;
    @(negedge clk); host_ovf_clr = 1'b0;
    idle(2);
    check("R7", "overflow cleared", int'(overflow), 0);

    phase = "R4_release";
    release_bank(0);
    fire(3, LEN + 10);
    check("R4", "bank 0 refilled", int'(last_bank), 0);

    phase = "R6_overwrite";
    policy_overwrite = 1'b1;
    fire(3, LEN + 10);
    check("R6", "bank 1 overwritten", int'(last_bank), 1);
    check("R6", "bank 1 still ready", int'(bank_ready[1]), 1);

    phase = "R8_missed";
    for (int i = 0; i < 60; i++) fire(2, 2);
    idle(LEN + 10);
    check("R8", "missed saturates", int'(missed_count), MMAX);

    phase = "R10_gaps";
    gap_mode = 1'b1;
    fire(3, 2 * LEN + 10);
    gap_mode = 1'b0;
    @(negedge clk); adc_valid = 1'b1;
    idle(2 * LEN + 4);

    phase = "R4_drain";
    release_bank(0);
    release_bank(1);
    idle(3);
    check("R4", "both released", int'(bank_ready), 0);
    idle(2 * LEN);

    done = 1'b1;
    finish_run();
  end
endmodule